// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces, one per clock, the column addresses of a single SDRAM read or write burst. A start pulse captures a 9-bit start column, a burst-length code and a burst-order select. From the next cycle on, the block presents one column per cycle with a valid strobe. On the final address of a fixed-length burst it also raises a last-beat flag.

Two orders are supported. In sequential order the low column bits count upward and wrap inside the aligned block that the burst length sets. In interleaved order each beat's column is the start column XORed with the beat index. A full-page burst walks all 512 columns, wraps from 511 to 0 and runs until it is terminated. A terminate input stops address issue at once. A fresh start pulse on any cycle drops the burst in flight and begins a new one.

Top module: `burst_col_gen`

## Requirements
- R1: In the cycle after `start` is sampled high, `col_valid` is 1 and `col` equals the `start_col` sampled with it.
- R2: `len_sel` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Exactly that many consecutive valid beats are issued. `last` is 1 only on the final beat, and `col_valid` is 0 in the cycle after it unless a new start was sampled.
- R3: When `ilv` is 0 with a fixed length N, beat n has column (start & ~(N-1)) | ((start + n) & (N-1)). The upper column bits stay fixed and the low bits wrap inside the aligned block.
- R4: When `ilv` is 1 with a fixed length, beat n has column start XOR n.
- R5: A `len_sel` code of 4 or above selects full page. Beat n has column (start + n) mod 512, so column 511 is followed by 0. `last` is never raised, and beats continue until terminate or a new start.
- R6: `term` sampled high (without `start`) makes `col_valid` 0 from the next cycle on. `term` while idle leaves `col_valid` at 0.
- R7: `start` sampled during a burst abandons it and begins the new burst per R1. When `start` and `term` are sampled in the same cycle, `start` wins.
- R8: If full page is requested with `ilv`=1, `bad_combo` is 1 on every beat of that burst and the addresses follow sequential full-page order. Otherwise `bad_combo` is 0.
- R9: While `rst_n` is low and after its release, `col_valid`, `last` and `bad_combo` are 0 until the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new burst (restarts one in flight) |
| start_col | input | 9 | First column of the burst |
| len_sel | input | 3 | Length code: 0=1, 1=2, 2=4, 3=8, 4..7=full page |
| ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| term | input | 1 | Stop the current burst |
| col_valid | output | 1 | A column address is presented |
| col | output | 9 | Current column address |
| last | output | 1 | Final beat of a fixed-length burst |
| bad_combo | output | 1 | Interleave requested with full page |

## Verification
Three events can land in the same cycle: the natural end of a burst, a terminate, and a new start. The bench asserts `start` and `term` together in the middle of an 8-beat burst and requires that the new burst's first column appears on the next cycle. It also issues a restart in the middle of a burst and a terminate in the middle of a full-page burst. In each case it checks that no column from the abandoned burst appears afterwards, comparing every beat against a column model computed from the stated formulas.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W     = 9,
  parameter int LEN_W     = 3,
  parameter int MAX_LOG   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [LEN_W-1:0] len_sel,
  input  logic             ilv,
  input  logic             term,
  output logic             col_valid,
  output logic [COL_W-1:0] col,
  output logic             last,
  output logic             bad_combo
);

  logic             active, ilv_r, full_r, bad_r;
  logic [COL_W-1:0] base, cnt, mask_r;

  wire              full_req = len_sel > LEN_W'(MAX_LOG);
  wire [COL_W-1:0]  mask_req = full_req ? {COL_W{1'b1}}
                                        : ((COL_W'(1) << len_sel) - COL_W'(1));
  wire [COL_W-1:0]  seq_col  = (base & ~mask_r) | ((base + cnt) & mask_r);
  wire              at_end   = !full_r && (cnt == mask_r);

  assign col       = ilv_r ? (base ^ cnt) : seq_col;
  assign col_valid = active;
  assign last      = active && at_end;
  assign bad_combo = active && bad_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ilv_r  <= 1'b0;
      full_r <= 1'b0;
      bad_r  <= 1'b0;
      base   <= '0;
      cnt    <= '0;
      mask_r <= '0;
    end else if (start) begin
      active <= 1'b1;
      base   <= start_col;
      cnt    <= '0;
      mask_r <= mask_req;
      full_r <= full_req;
      ilv_r  <= ilv && !full_req;
      bad_r  <= ilv && full_req;
    end else if (term) begin
      active <= 1'b0;
    end else if (active) begin
      if (at_end) active <= 1'b0;
      else        cnt    <= cnt + COL_W'(1);
    end
  end

  // R1, R7
  a_r1_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col == $past(start_col)));

  // R2
  a_r2_last_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !col_valid);

  a_r2_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> col_valid);

  // R3, R5
  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !last && !start && !term && !ilv_r)
      |=> (((col - $past(col)) & $past(mask_r)) == COL_W'(1)));

  // R6
  a_r6_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !start) |=> !col_valid);

  // R8
  a_r8_bad_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    bad_combo |-> (col_valid && !last));

endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, ilv = 1'b0, term = 1'b0;
  logic [8:0] start_col = '0;
  logic [2:0] len_sel = '0;
  logic       col_valid, last, bad_combo;
  logic [8:0] col;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_col_gen u0 (.clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_sel(len_sel), .ilv(ilv), .term(term), .col_valid(col_valid), .col(col),
    .last(last), .bad_combo(bad_combo));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int exp_col(int b, int n, int lg, bit il, bit fp);
    int m;
    if (fp) return (b + n) % 512;
    m = (1 << lg) - 1;
    if (il) return b ^ n;
    return (b & ~m) | ((b + n) & m);
  endfunction

  task automatic kick(int c, int ls, bit il);
    start = 1; start_col = 9'(c); len_sel = 3'(ls); ilv = il;
    step();
    start = 0;
  endtask

  task automatic check_beat(string req, int b, int n, int lg, bit il, bit fp, bit lst);
    chk(col_valid == 1, req, "valid", int'(col_valid), 1);
    chk(int'(col) == exp_col(b, n, lg, il, fp), req, "col", int'(col), exp_col(b, n, lg, il, fp));
    chk(last == lst, req, "last", int'(last), int'(lst));
  endtask

  // R1 R2 R3 R4
  task automatic t_fixed(int c, int lg, bit il, string req);
    int nb = 1 << lg;
    kick(c, lg, il);
    for (int n = 0; n < nb; n++) begin
      if (n > 0) step();
      check_beat(req, c, n, lg, il, 0, n == nb - 1);
      chk(bad_combo == 0, "R8", "bad_combo fixed", int'(bad_combo), 0);
    end
    step();
    chk(col_valid == 0, "R2", "valid after last", int'(col_valid), 0);
  endtask

  // R5 R6
  task automatic t_fullpage();
    kick(9'h1FA, 4, 0);
    for (int n = 0; n < 12; n++) begin
      if (n > 0) step();
      check_beat("R5", 9'h1FA, n, 0, 0, 1, 0);
    end
    term = 1; step(); term = 0;
    chk(col_valid == 0, "R6", "valid after term", int'(col_valid), 0);
    step();
    chk(col_valid == 0, "R6", "valid stays low", int'(col_valid), 0);
    term = 1; step(); term = 0;
    chk(col_valid == 0, "R6", "term while idle", int'(col_valid), 0);
  endtask

  // R7
  task automatic t_restart();
    kick(9'h010, 3, 0);
    step(); step();
    check_beat("R7", 9'h010, 2, 3, 0, 0, 0);
    kick(9'h033, 2, 1);
    for (int n = 0; n < 4; n++) begin
      if (n > 0) step();
      check_beat("R7", 9'h033, n, 2, 1, 0, n == 3);
    end
    step();
    chk(col_valid == 0, "R7", "idle after restarted burst", int'(col_valid), 0);
    kick(9'h0A5, 3, 0);
    step();
    term = 1;
    kick(9'h144, 1, 0);
    term = 0;
    check_beat("R7", 9'h144, 0, 1, 0, 0, 0);
    step();
    check_beat("R7", 9'h144, 1, 1, 0, 0, 1);
    step();
    chk(col_valid == 0, "R7", "idle after start+term burst", int'(col_valid), 0);
  endtask

  // R8
  task automatic t_badcombo();
    kick(9'h1FE, 7, 1);
    for (int n = 0; n < 5; n++) begin
      if (n > 0) step();
      check_beat("R8", 9'h1FE, n, 0, 0, 1, 0);
      chk(bad_combo == 1, "R8", "bad_combo", int'(bad_combo), 1);
    end
    term = 1; step(); term = 0;
    chk(bad_combo == 0, "R8", "bad_combo after term", int'(bad_combo), 0);
  endtask

  initial begin
    step(); step();
    chk(col_valid == 0 && last == 0 && bad_combo == 0, "R9", "outputs in reset",
        int'({col_valid, last, bad_combo}), 0);
    rst_n = 1; step();
    chk(col_valid == 0 && last == 0 && bad_combo == 0, "R9", "outputs after reset",
        int'({col_valid, last, bad_combo}), 0);
    t_fixed(9'h0A3, 0, 0, "R2");
    t_fixed(9'h0A3, 1, 0, "R3");
    t_fixed(9'h0A6, 2, 0, "R3");
    t_fixed(9'h0AD, 3, 0, "R3");
    t_fixed(9'h1FF, 3, 0, "R3");
    t_fixed(9'h0A6, 2, 1, "R4");
    t_fixed(9'h0AD, 3, 1, "R4");
    t_fixed(9'h0A1, 1, 1, "R4");
    t_fullpage();
    t_restart();
    t_badcombo();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule